// File: doc/BRIEF.md
# Serial Link Hardware Handshake Controller

This block manages the two handshake wires of one serial channel. On the transmit side it watches an active-low clear-to-send pin (`cts_n`). When transmit flow control is switched on, it withholds the start grant for each new frame while the far end signals that it is not ready. A frame that the shifter has already started is not affected, because only the start handshake is gated. A change on the same pin can set a sticky interrupt flag. A two-bit mode selects whether rising edges, falling edges, both or neither count.

On the receive side it drives an active-low request-to-send pin (`rts_n`). The pin goes high, which asks the far end to pause, when the receive FIFO holds at least a programmable number of bytes and receive flow control is on. A software hold bit also drives the pin high. The pin drops low again once the FIFO level falls under the trigger and the hold bit is clear. Serial shifting and FIFO storage are outside this block. It only sees the FIFO occupancy count and a request/grant pair from the transmit shifter.

Top module: `hs_flow_ctrl`

## Requirements
- R1: After reset, `rts_n` is 0, `irq` is 0 and both flow enables are clear, so `tx_grant` follows `tx_req` whatever the level of `cts_n`.
- R2: When the transmit enable (control bit 0) is clear, `tx_grant` equals `tx_req` for every level of `cts_n`.
- R3: When the transmit enable is set, `cts_n` passes through a two-stage synchronizer. `tx_grant` is 0 while the synchronized level is high and equals `tx_req` while it is low. A new `cts_n` level reaches `tx_grant` after two rising clock edges.
- R4: The interrupt mode is control bits [4:3]: 00 none, 01 rising edge of `cts_n` (low to high), 10 falling edge, 11 both. A selected edge sets `irq` on the third rising clock edge after the pin changes, and an edge that is not selected leaves `irq` at 0.
- R5: `irq` stays set until a write with `cfg_sel`=1 carries 1 in data bit 0. Such a write with bit 0 equal to 0 has no effect. When a new selected edge and a clear arrive in the same cycle, the flag stays set.
- R6: With the receive enable (control bit 1) set, `rts_n` is 1 one clock edge after the FIFO count is at or above the trigger level (control bits [9:5], range 0..16). A trigger of 0 keeps `rts_n` high.
- R7: `rts_n` is 0 one clock edge after the FIFO count is below the trigger level and the software hold bit is clear.
- R8: When the receive enable is clear, the FIFO count has no effect on `rts_n`.
- R9: The software hold bit (control bit 2) forces `rts_n` to 1 one clock edge later, whatever the receive enable and the FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the interrupt clear |
| cfg_wdata | input | CFG_W (10) | Write data |
| rx_fifo_count | input | CNT_W (5) | Bytes currently held in the receive FIFO |
| tx_req | input | 1 | Shifter asks to start a new frame |
| tx_grant | output | 1 | Frame start allowed |
| cts_n | input | 1 | Clear-to-send pin, low means the far end is ready |
| rts_n | output | 1 | Request-to-send pin, high asks the far end to pause |
| irq | output | 1 | Sticky clear-to-send change interrupt |

## Verification
The receive side is tested with a table of counts just below, at and above the trigger, with a zero trigger, and with the enable or the hold bit toggled. A comparator off by one, or a count that leaks through a disabled enable, shows up as a wrong `rts_n` level. On the transmit side the grant is sampled after the first and the second clock edge following a pin change, so a missing or extra synchronizer stage changes the observed grant. The interrupt tests drive each edge direction under each mode. They write 0 and then 1 to the clear bit, and they line a clear up with a fresh edge, so a swapped mode decode, a flag that is not sticky or a clear that wins over a set each leave `irq` at the wrong value.

// File: rtl/hs_flow_pkg.sv
package hs_flow_pkg;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'b00,
        IRQ_RISE = 2'b01,
        IRQ_FALL = 2'b10,
        IRQ_BOTH = 2'b11
    } irq_mode_e;

    localparam int CTRL_TX_EN   = 0;
    localparam int CTRL_RX_EN   = 1;
    localparam int CTRL_SW_HOLD = 2;
    localparam int CTRL_MODE_LO = 3;
    localparam int CTRL_TRIG_LO = 5;
    localparam int STAT_CLR_BIT = 0;

endpackage

// File: rtl/flow_cfg_regs.sv
module flow_cfg_regs
    import hs_flow_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int CFG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tx_en,
    output logic             rx_en,
    output logic             sw_hold,
    output irq_mode_e        irq_mode,
    output logic [LVL_W-1:0] trig,
    output logic             irq_clr
);

    typedef struct packed {
        logic             tx_en;
        logic             rx_en;
        logic             sw_hold;
        irq_mode_e        mode;
        logic [LVL_W-1:0] trig;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cfg_we && !cfg_sel) begin
            ctrl_d.tx_en   = cfg_wdata[CTRL_TX_EN];
            ctrl_d.rx_en   = cfg_wdata[CTRL_RX_EN];
            ctrl_d.sw_hold = cfg_wdata[CTRL_SW_HOLD];
            ctrl_d.mode    = irq_mode_e'(cfg_wdata[CTRL_MODE_LO +: 2]);
            ctrl_d.trig    = cfg_wdata[CTRL_TRIG_LO +: LVL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign tx_en    = ctrl_q.tx_en;
    assign rx_en    = ctrl_q.rx_en;
    assign sw_hold  = ctrl_q.sw_hold;
    assign irq_mode = ctrl_q.mode;
    assign trig     = ctrl_q.trig;
    assign irq_clr  = cfg_we && cfg_sel && cfg_wdata[STAT_CLR_BIT];

endmodule

// File: rtl/cts_monitor.sv
module cts_monitor
    import hs_flow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cts_n,
    input  irq_mode_e irq_mode,
    input  logic      irq_clr,
    output logic      cts_busy,
    output logic      irq
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   irq;
    } mon_t;

    mon_t mon_d, mon_q;
    logic rise, fall, hit;

    always_comb begin
        rise = mon_q.sync[SYNC_STAGES-1] && !mon_q.prev;
        fall = !mon_q.sync[SYNC_STAGES-1] && mon_q.prev;
        unique case (irq_mode)
            IRQ_RISE: hit = rise;
            IRQ_FALL: hit = fall;
            IRQ_BOTH: hit = rise || fall;
            default:  hit = 1'b0;
        endcase
        mon_d      = mon_q;
        mon_d.sync = {mon_q.sync[SYNC_STAGES-2:0], cts_n};
        mon_d.prev = mon_q.sync[SYNC_STAGES-1];
        mon_d.irq  = hit || (mon_q.irq && !irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.sync <= '1;
            mon_q.prev <= 1'b1;
            mon_q.irq  <= 1'b0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign cts_busy = mon_q.sync[SYNC_STAGES-1];
    assign irq      = mon_q.irq;

    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_irq_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == IRQ_NONE && !irq) |=> !irq);

    assert_irq_rise_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == IRQ_RISE && !irq && !cts_busy) |=> !irq);

endmodule

// File: rtl/rts_driver.sv
module rts_driver #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig,
    input  logic             rx_en,
    input  logic             sw_hold,
    output logic             rts_n
);

    typedef struct packed {
        logic pause;
    } rts_t;

    rts_t rts_d, rts_q;

    always_comb begin
        rts_d       = rts_q;
        rts_d.pause = sw_hold || (rx_en && (fifo_count >= trig));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_q <= '0;
        end else begin
            rts_q <= rts_d;
        end
    end

    assign rts_n = rts_q.pause;

    assert_sw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hold |=> rts_n);

    assert_level_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && fifo_count >= trig) |=> rts_n);

    assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_hold && (!rx_en || fifo_count < trig)) |=> !rts_n);

endmodule

// File: rtl/hs_flow_ctrl.sv
module hs_flow_ctrl
    import hs_flow_pkg::*;
#(
    parameter  int FIFO_DEPTH  = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int CNT_W       = $clog2(FIFO_DEPTH + 1),
    localparam int CFG_W       = CTRL_TRIG_LO + CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [CNT_W-1:0] rx_fifo_count,
    input  logic             tx_req,
    output logic             tx_grant,
    input  logic             cts_n,
    output logic             rts_n,
    output logic             irq
);

    logic             tx_en, rx_en, sw_hold, irq_clr, cts_busy;
    irq_mode_e        irq_mode;
    logic [CNT_W-1:0] trig;

    flow_cfg_regs #(.LVL_W(CNT_W), .CFG_W(CFG_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .sw_hold  (sw_hold),
        .irq_mode (irq_mode),
        .trig     (trig),
        .irq_clr  (irq_clr)
    );

    cts_monitor #(.SYNC_STAGES(SYNC_STAGES)) i_cts (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_n   (cts_n),
        .irq_mode(irq_mode),
        .irq_clr (irq_clr),
        .cts_busy(cts_busy),
        .irq     (irq)
    );

    rts_driver #(.CNT_W(CNT_W)) i_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_count(rx_fifo_count),
        .trig      (trig),
        .rx_en     (rx_en),
        .sw_hold   (sw_hold),
        .rts_n     (rts_n)
    );

    assign tx_grant = tx_req && !(tx_en && cts_busy);

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && cts_busy) |-> !tx_grant);

    assert_tx_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (tx_grant == tx_req));

endmodule

// File: tb/test_hs_flow_ctrl.sv
module test_hs_flow_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int CFG_W      = 5 + CNT_W;

    // vector: {req id, ctrl word, fifo count, expected rts_n}
    localparam int VEC_W = 4 + CFG_W + CNT_W + 1;
    localparam int NVEC  = 9;
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {4'd7, 10'h102, 5'd7,  1'b0},
        {4'd6, 10'h102, 5'd8,  1'b1},
        {4'd6, 10'h102, 5'd16, 1'b1},
        {4'd7, 10'h102, 5'd0,  1'b0},
        {4'd8, 10'h100, 5'd16, 1'b0},
        {4'd9, 10'h004, 5'd0,  1'b1},
        {4'd9, 10'h206, 5'd3,  1'b1},
        {4'd6, 10'h002, 5'd0,  1'b1},
        {4'd7, 10'h202, 5'd15, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_sel = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CNT_W-1:0] rx_fifo_count = '0;
    logic             tx_req = 1'b0;
    logic             cts_n = 1'b1;
    logic             tx_grant, rts_n, irq;
    int               checks = 0;
    int               fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hs_flow_ctrl #(.FIFO_DEPTH(DEPTH)) i_hs_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_fifo_count(rx_fifo_count),
        .tx_req(tx_req), .tx_grant(tx_grant), .cts_n(cts_n),
        .rts_n(rts_n), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [CFG_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic string req_name(input logic [3:0] id);
        case (id)
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // reset state (R1)
        wait_cyc(3);
        rst_n = 1'b1;
        tx_req = 1'b1;
        wait_cyc(1);
        check("R1 rts_n", rts_n, 0);
        check("R1 irq", irq, 0);
        check("R1 grant with cts high", tx_grant, 1);

        // R2: transmit gating off, cts low and high
        cts_n = 1'b0; wait_cyc(3);
        check("R2 grant cts low", tx_grant, 1);
        cts_n = 1'b1; wait_cyc(3);
        check("R2 grant cts high", tx_grant, 1);

        // receive side table (R6..R9)
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0]       id;
            logic [CFG_W-1:0] c;
            logic [CNT_W-1:0] n;
            logic             e;
            {id, c, n, e} = VECS[i];
            rx_fifo_count = n;
            cfg_write(1'b0, c);
            wait_cyc(1);
            check(req_name(id), rts_n, e);
        end
        cfg_write(1'b0, '0);
        rx_fifo_count = '0;

        // R3: transmit gating on, sync latency
        cfg_write(1'b0, 10'h001);
        check("R3 held while cts high", tx_grant, 0);
        cts_n = 1'b0;
        wait_cyc(1);
        check("R3 still held after one edge", tx_grant, 0);
        wait_cyc(1);
        check("R3 released after two edges", tx_grant, 1);
        tx_req = 1'b0; wait_cyc(1);
        check("R3 no request no grant", tx_grant, 0);
        tx_req = 1'b1;

        // R4: mode none
        cts_n = 1'b1; wait_cyc(4);
        check("R4 none ignores rise", irq, 0);
        check("R3 held after cts high", tx_grant, 0);
        cts_n = 1'b0; wait_cyc(4);
        check("R4 none ignores fall", irq, 0);

        // R4/R5: rising mode
        cfg_write(1'b0, 10'h009);
        cts_n = 1'b1;
        wait_cyc(2);
        check("R4 irq not yet after two edges", irq, 0);
        wait_cyc(1);
        check("R4 rise sets irq on third edge", irq, 1);
        wait_cyc(3);
        check("R5 sticky", irq, 1);
        cfg_write(1'b1, 10'h000);
        check("R5 write zero keeps flag", irq, 1);
        cfg_write(1'b1, 10'h001);
        check("R5 write one clears", irq, 0);
        cts_n = 1'b0; wait_cyc(4);
        check("R4 rise mode ignores fall", irq, 0);

        // falling mode
        cfg_write(1'b0, 10'h011);
        cts_n = 1'b1; wait_cyc(4);
        check("R4 fall mode ignores rise", irq, 0);
        cts_n = 1'b0; wait_cyc(4);
        check("R4 fall sets irq", irq, 1);
        cfg_write(1'b1, 10'h001);
        check("R5 clear after fall", irq, 0);

        // both edges, then set beats clear
        cfg_write(1'b0, 10'h019);
        cts_n = 1'b1; wait_cyc(4);
        check("R4 both mode rise", irq, 1);
        cfg_write(1'b1, 10'h001);
        check("R5 clear in both mode", irq, 0);
        cts_n = 1'b0;
        wait_cyc(2);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 10'h001;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R5 set wins over clear", irq, 1);
        cfg_write(1'b1, 10'h001);
        check("R5 final clear", irq, 0);

        // R2 again: enable off with cts high
        cts_n = 1'b1;
        cfg_write(1'b0, 10'h000);
        wait_cyc(3);
        check("R2 disabled after use", tx_grant, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule